// File: doc/BRIEF.md
# Dual 40-bit Accumulator Register File with Scaling and Saturation

The block holds two 40-bit accumulators, A and B, as used by a fixed-point arithmetic datapath. Each accumulator is stored as three parts: an 8-bit guard (extension) byte on top, a 16-bit high word and a 16-bit low word. A 16-bit data-bus port reads and writes each part. The same port can also load a whole accumulator from one 16-bit operand, which fills the guard byte with sign copies and clears the low word. A second 16-bit bus port can write only the high word.

A 40-bit result from the arithmetic unit is written into a selected accumulator. On the way in, the result passes through a scaling shifter and then through an optional clamp to the signed 32-bit range. The block raises a sticky limit flag whenever the clamp changes a value. The block leaves out the multiply-accumulate logic, the decoder and the rest of the status word. Its ports stand in for them.

Top module: `acc_pair_regfile`

## Requirements
- R1: An active-low asynchronous reset (rst_ni low) clears both accumulators (a_o, b_o) and lim_o to zero at once.
- R2: With dbus_we_i high, field code 2'b00 writes dbus_wdata_i into bits 15:0 and code 2'b01 writes it into bits 31:16 of the accumulator chosen by dbus_acc_i (0 = A, 1 = B). All other bits stay unchanged. dbus_rdata_o returns the same part combinationally for the current dbus_acc_i and dbus_fld_i.
- R3: Field code 2'b10 addresses the guard byte (bits 39:32). A write stores only dbus_wdata_i[7:0] and ignores bits 15:8. A read returns the byte in bits 7:0, with bits 15:8 all equal to bit 7 of the byte.
- R4: A write with field code 2'b11 loads the accumulator with {8 copies of wdata[15], wdata, 16'h0000}. A read with code 2'b11 returns the high word.
- R5: A write through the global port (gbus_we_i) changes only bits 31:16 of the accumulator chosen by gbus_acc_i.
- R6: A result write (res_we_i) stores res_data_i after scaling by scale_mode_i. Code 2'b00 applies no shift. Code 2'b01 shifts right by one bit with the sign preserved. Code 2'b10 shifts left by one bit and drops bit 39. Code 2'b11 applies no shift.
- R7: With sat_en_i high, a scaled result above 0x00_7FFF_FFFF is stored as 0x00_7FFF_FFFF, and one below 0xFF_8000_0000 (signed) is stored as 0xFF_8000_0000. With sat_en_i low, the full 40-bit scaled value is stored.
- R8: lim_o goes high in the cycle after a result write is clamped. It then stays high until a cycle with lim_clr_i high and no new clamp. A clamp in the same cycle as lim_clr_i leaves the flag set.
- R9: On the same accumulator in the same cycle, a result write overrides a data-bus write, and a data-bus write to the high word overrides a global-bus write. Writes that touch different parts or different accumulators all take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dbus_we_i | input | 1 | Data-bus write strobe |
| dbus_acc_i | input | 1 | Data-bus accumulator select (0 = A, 1 = B) |
| dbus_fld_i | input | 2 | Part select: 00 low, 01 high, 10 guard, 11 whole |
| dbus_wdata_i | input | 16 | Data-bus write word |
| dbus_rdata_o | output | 16 | Data-bus read word for the selected part |
| gbus_we_i | input | 1 | Global-bus high-word write strobe |
| gbus_acc_i | input | 1 | Global-bus accumulator select |
| gbus_wdata_i | input | 16 | Global-bus write word |
| res_we_i | input | 1 | Arithmetic result write strobe |
| res_acc_i | input | 1 | Result destination select |
| res_data_i | input | 40 | Unscaled arithmetic result |
| scale_mode_i | input | 2 | Scaling mode code |
| sat_en_i | input | 1 | Enable 32-bit saturation |
| lim_clr_i | input | 1 | Clear the limit flag |
| lim_o | output | 1 | Sticky limit flag |
| a_o | output | 40 | Accumulator A contents |
| b_o | output | 40 | Accumulator B contents |

## Verification
The assertions assume that the strobes, the selects and the mode inputs hold known values in every cycle after reset is released. The properties on the next state of an accumulator would not be meaningful if an unknown strobe were present. The bench drives every input to a defined value from time zero and changes inputs only just after a rising edge, so each write strobe lasts exactly one cycle. The result sweep feeds only fully defined 40-bit patterns, so the range checks of the clamp always see a signed value that can be compared.

// File: rtl/acc_pkg.sv
`timescale 1ns/1ps
package acc_pkg;
  typedef enum logic [1:0] {
    FLD_LO    = 2'b00,
    FLD_HI    = 2'b01,
    FLD_GUARD = 2'b10,
    FLD_WHOLE = 2'b11
  } fld_e;

  typedef enum logic [1:0] {
    SC_NONE  = 2'b00,
    SC_RIGHT = 2'b01,
    SC_LEFT  = 2'b10,
    SC_RSVD  = 2'b11
  } scale_e;
endpackage

// File: rtl/acc_scale_sat.sv
`timescale 1ns/1ps
module acc_scale_sat
  import acc_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int EXT_W  = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [EXT_W+2*WORD_W-1:0]     data_i,
  input  logic [1:0]                    mode_i,
  input  logic                          sat_en_i,
  output logic [EXT_W+2*WORD_W-1:0]     data_o,
  output logic                          clamp_o
);
  localparam int ACC_W = EXT_W + 2*WORD_W;
  localparam int SAT_W = 2*WORD_W;
  localparam int TOP_W = ACC_W - SAT_W + 1;
  localparam logic [ACC_W-1:0] POS_LIM = {{TOP_W{1'b0}}, {(SAT_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NEG_LIM = ~POS_LIM;

  logic [ACC_W-1:0] scaled;
  logic [TOP_W-1:0] top_bits;
  logic             fits;

  always_comb begin
    unique case (scale_e'(mode_i))
      SC_RIGHT: scaled = {data_i[ACC_W-1], data_i[ACC_W-1:1]};
      SC_LEFT:  scaled = {data_i[ACC_W-2:0], 1'b0};
      default:  scaled = data_i;
    endcase
  end

  // value fits in SAT_W signed bits when all bits from SAT_W-1 upward agree
  assign top_bits = scaled[ACC_W-1:SAT_W-1];
  assign fits     = (&top_bits) | ~(|top_bits);
  assign clamp_o  = sat_en_i & ~fits;
  assign data_o   = clamp_o ? (scaled[ACC_W-1] ? NEG_LIM : POS_LIM) : scaled;

  // R7
  sat_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_en_i |-> ((&data_o[ACC_W-1:SAT_W-1]) || !(|data_o[ACC_W-1:SAT_W-1])));

  // R6
  no_scale_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sat_en_i && (mode_i == SC_NONE || mode_i == SC_RSVD)) |-> (data_o == data_i));
endmodule

// File: rtl/acc_slot.sv
`timescale 1ns/1ps
module acc_slot
  import acc_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int EXT_W  = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      dbus_we_i,
  input  logic [1:0]                dbus_fld_i,
  input  logic [WORD_W-1:0]         dbus_wdata_i,
  input  logic                      gbus_we_i,
  input  logic [WORD_W-1:0]         gbus_wdata_i,
  input  logic                      res_we_i,
  input  logic [EXT_W+2*WORD_W-1:0] res_data_i,
  output logic [EXT_W+2*WORD_W-1:0] acc_o
);
  localparam int ACC_W = EXT_W + 2*WORD_W;
  localparam int HI_LSB = WORD_W;
  localparam int EXT_LSB = 2*WORD_W;

  logic [ACC_W-1:0] acc_q, acc_d;

  // priority: result > data bus > global bus
  always_comb begin
    acc_d = acc_q;
    if (gbus_we_i) acc_d[HI_LSB +: WORD_W] = gbus_wdata_i;
    if (dbus_we_i) begin
      unique case (fld_e'(dbus_fld_i))
        FLD_LO:    acc_d[0 +: WORD_W]       = dbus_wdata_i;
        FLD_HI:    acc_d[HI_LSB +: WORD_W]  = dbus_wdata_i;
        FLD_GUARD: acc_d[EXT_LSB +: EXT_W]  = dbus_wdata_i[EXT_W-1:0];
        default:   acc_d = {{EXT_W{dbus_wdata_i[WORD_W-1]}}, dbus_wdata_i, {WORD_W{1'b0}}};
      endcase
    end
    if (res_we_i) acc_d = res_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  // R4
  whole_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbus_we_i && dbus_fld_i == FLD_WHOLE && !res_we_i) |=>
      (acc_q[ACC_W-1:EXT_LSB] == {EXT_W{acc_q[EXT_LSB-1]}}) && (acc_q[WORD_W-1:0] == '0));

  // R5
  gbus_hi_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gbus_we_i && !dbus_we_i && !res_we_i) |=>
      (acc_q[WORD_W-1:0] == $past(acc_q[WORD_W-1:0])) &&
      (acc_q[ACC_W-1:EXT_LSB] == $past(acc_q[ACC_W-1:EXT_LSB])));
endmodule

// File: rtl/acc_word_read.sv
`timescale 1ns/1ps
module acc_word_read
  import acc_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int EXT_W  = 8
) (
  input  logic [EXT_W+2*WORD_W-1:0] acc_i,
  input  logic [1:0]                fld_i,
  output logic [WORD_W-1:0]         rdata_o
);
  localparam int ACC_W = EXT_W + 2*WORD_W;

  always_comb begin
    unique case (fld_e'(fld_i))
      FLD_LO:    rdata_o = acc_i[0 +: WORD_W];
      FLD_GUARD: rdata_o = {{(WORD_W-EXT_W){acc_i[ACC_W-1]}}, acc_i[ACC_W-1 -: EXT_W]};
      default:   rdata_o = acc_i[WORD_W +: WORD_W];
    endcase
  end
endmodule

// File: rtl/acc_pair_regfile.sv
`timescale 1ns/1ps
module acc_pair_regfile
  import acc_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int EXT_W  = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      dbus_we_i,
  input  logic                      dbus_acc_i,
  input  logic [1:0]                dbus_fld_i,
  input  logic [WORD_W-1:0]         dbus_wdata_i,
  output logic [WORD_W-1:0]         dbus_rdata_o,
  input  logic                      gbus_we_i,
  input  logic                      gbus_acc_i,
  input  logic [WORD_W-1:0]         gbus_wdata_i,
  input  logic                      res_we_i,
  input  logic                      res_acc_i,
  input  logic [EXT_W+2*WORD_W-1:0] res_data_i,
  input  logic [1:0]                scale_mode_i,
  input  logic                      sat_en_i,
  input  logic                      lim_clr_i,
  output logic                      lim_o,
  output logic [EXT_W+2*WORD_W-1:0] a_o,
  output logic [EXT_W+2*WORD_W-1:0] b_o
);
  localparam int ACC_W   = EXT_W + 2*WORD_W;
  localparam int SAT_W   = 2*WORD_W;
  localparam int NUM_ACC = 2;

  logic [ACC_W-1:0] res_val;
  logic             res_clamp;
  logic [ACC_W-1:0] acc_q [NUM_ACC];
  logic             lim_q;

  acc_scale_sat #(.WORD_W(WORD_W), .EXT_W(EXT_W)) i_scale_sat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .data_i   (res_data_i),
    .mode_i   (scale_mode_i),
    .sat_en_i (sat_en_i),
    .data_o   (res_val),
    .clamp_o  (res_clamp)
  );

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_slot
    acc_slot #(.WORD_W(WORD_W), .EXT_W(EXT_W)) i_slot (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .dbus_we_i    (dbus_we_i && (dbus_acc_i == 1'(g))),
      .dbus_fld_i   (dbus_fld_i),
      .dbus_wdata_i (dbus_wdata_i),
      .gbus_we_i    (gbus_we_i && (gbus_acc_i == 1'(g))),
      .gbus_wdata_i (gbus_wdata_i),
      .res_we_i     (res_we_i && (res_acc_i == 1'(g))),
      .res_data_i   (res_val),
      .acc_o        (acc_q[g])
    );
  end

  acc_word_read #(.WORD_W(WORD_W), .EXT_W(EXT_W)) i_word_read (
    .acc_i   (acc_q[dbus_acc_i]),
    .fld_i   (dbus_fld_i),
    .rdata_o (dbus_rdata_o)
  );

  // a new clamp outranks a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    lim_q <= 1'b0;
    else if (res_we_i && res_clamp) lim_q <= 1'b1;
    else if (lim_clr_i)             lim_q <= 1'b0;
  end

  assign lim_o = lim_q;
  assign a_o   = acc_q[0];
  assign b_o   = acc_q[1];

  // R8
  lim_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_o && !lim_clr_i) |=> lim_o);

  // R8
  lim_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_we_i && sat_en_i && scale_mode_i == SC_NONE &&
     !((&res_data_i[ACC_W-1:SAT_W-1]) || !(|res_data_i[ACC_W-1:SAT_W-1]))) |=> lim_o);

  // R3
  guard_sign_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbus_fld_i == FLD_GUARD) |->
      (dbus_rdata_o[WORD_W-1:EXT_W] == {(WORD_W-EXT_W){dbus_rdata_o[EXT_W-1]}}));

  // R9
  res_wins_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_we_i && !res_acc_i) |=> (a_o == $past(res_val)));

  // R9
  res_wins_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_we_i && res_acc_i) |=> (b_o == $past(res_val)));
endmodule

// File: tb/test_acc_pair_regfile.sv
`timescale 1ns/1ps
module test_acc_pair_regfile;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dbus_we_i = 1'b0, dbus_acc_i = 1'b0;
  logic [1:0]  dbus_fld_i = 2'b00;
  logic [15:0] dbus_wdata_i = '0;
  logic [15:0] dbus_rdata_o;
  logic        gbus_we_i = 1'b0, gbus_acc_i = 1'b0;
  logic [15:0] gbus_wdata_i = '0;
  logic        res_we_i = 1'b0, res_acc_i = 1'b0;
  logic [39:0] res_data_i = '0;
  logic [1:0]  scale_mode_i = 2'b00;
  logic        sat_en_i = 1'b0, lim_clr_i = 1'b0;
  logic        lim_o;
  logic [39:0] a_o, b_o;

  acc_pair_regfile i_acc_pair_regfile (.*);

  always #2 clk_i = ~clk_i;

  logic [39:0] m [2];
  logic        mlim;
  int unsigned n_vec = 0, n_err = 0;
  bit          done = 1'b0;

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk(req, a_o, m[0]);
    chk(req, b_o, m[1]);
    chk(req, {39'd0, lim_o}, {39'd0, mlim});
  endtask

  function automatic logic [39:0] f_dwr(input logic [39:0] old, input logic [1:0] fld, input logic [15:0] w);
    logic [39:0] r = old;
    case (fld)
      2'b00: r[15:0]  = w;
      2'b01: r[31:16] = w;
      2'b10: r[39:32] = w[7:0];
      default: r = {{8{w[15]}}, w, 16'h0000};
    endcase
    return r;
  endfunction

  function automatic logic [15:0] f_rd(input logic [39:0] v, input logic [1:0] fld);
    case (fld)
      2'b00:   return v[15:0];
      2'b10:   return {{8{v[39]}}, v[39:32]};
      default: return v[31:16];
    endcase
  endfunction

  function automatic logic [39:0] f_scale(input logic [39:0] x, input logic [1:0] md);
    case (md)
      2'b01:   return {x[39], x[39:1]};
      2'b10:   return {x[38:0], 1'b0};
      default: return x;
    endcase
  endfunction

  task automatic tick();
    @(posedge clk_i);
    #1;
    dbus_we_i = 1'b0; gbus_we_i = 1'b0; res_we_i = 1'b0; lim_clr_i = 1'b0;
  endtask

  task automatic dwr(input bit acc, input logic [1:0] fld, input logic [15:0] w);
    dbus_we_i = 1'b1; dbus_acc_i = acc; dbus_fld_i = fld; dbus_wdata_i = w;
    tick();
    m[acc] = f_dwr(m[acc], fld, w);
  endtask

  task automatic rchk(input string req, input bit acc, input logic [1:0] fld);
    dbus_acc_i = acc; dbus_fld_i = fld;
    #0.5;
    chk(req, {24'd0, dbus_rdata_o}, {24'd0, f_rd(m[acc], fld)});
  endtask

  task automatic rwr(input bit acc, input logic [39:0] x, input logic [1:0] md, input bit sat, input bit clr);
    logic signed [39:0] s;
    logic [39:0] v;
    bit clamp;
    res_we_i = 1'b1; res_acc_i = acc; res_data_i = x;
    scale_mode_i = md; sat_en_i = sat; lim_clr_i = clr;
    tick();
    s = f_scale(x, md);
    v = s;
    clamp = 1'b0;
    if (sat && s > 40'sd2147483647) begin v = 40'h00_7FFF_FFFF; clamp = 1'b1; end
    else if (sat && s < -40'sd2147483648) begin v = 40'hFF_8000_0000; clamp = 1'b1; end
    m[acc] = v;
    mlim = clamp ? 1'b1 : (clr ? 1'b0 : mlim);
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    m[0] = '0; m[1] = '0; mlim = 1'b0;
    repeat (3) @(posedge clk_i);
    #1;
    chk_state("R1 reset");
    rst_ni = 1'b1;
    tick();
    chk_state("R1 after release");

    // R2 low/high word writes and readback
    for (int i = 0; i < 256; i++) begin
      for (int a = 0; a < 2; a++) begin
        dwr(a[0], 2'b00, 16'(i * 257) ^ 16'h5A3C);
        chk_state("R2 low write");
        rchk("R2 low read", a[0], 2'b00);
        dwr(a[0], 2'b01, 16'(i * 1031) ^ 16'hC3A5);
        chk_state("R2 high write");
        rchk("R2 high read", a[0], 2'b01);
      end
    end

    // R3 guard byte: upper write bits ignored, read sign-extended
    for (int i = 0; i < 256; i++) begin
      for (int a = 0; a < 2; a++) begin
        dwr(a[0], 2'b10, {~8'(i), 8'(i)});
        chk_state("R3 guard write");
        rchk("R3 guard read", a[0], 2'b10);
      end
    end

    // R4 whole-accumulator short write
    for (int i = 0; i < 256; i++) begin
      for (int a = 0; a < 2; a++) begin
        dwr(a[0], 2'b11, {8'(i), ~8'(i * 3)});
        chk_state("R4 whole write");
        rchk("R4 whole read", a[0], 2'b11);
      end
    end

    // R5 global port writes high word only
    for (int i = 0; i < 64; i++) begin
      dwr(1'b0, 2'b10, 16'h00A5); dwr(1'b0, 2'b00, 16'h1234);
      gbus_we_i = 1'b1; gbus_acc_i = i[0]; gbus_wdata_i = 16'(i * 4099) ^ 16'h8001;
      tick();
      m[i[0]][31:16] = 16'(i * 4099) ^ 16'h8001;
      chk_state("R5 global high write");
    end

    // R9 priority and independence
    dbus_we_i = 1'b1; dbus_acc_i = 1'b0; dbus_fld_i = 2'b00; dbus_wdata_i = 16'h1111;
    gbus_we_i = 1'b1; gbus_acc_i = 1'b0; gbus_wdata_i = 16'h2222;
    tick();
    m[0][15:0] = 16'h1111; m[0][31:16] = 16'h2222;
    chk_state("R9 low and global both apply");
    dbus_we_i = 1'b1; dbus_acc_i = 1'b1; dbus_fld_i = 2'b01; dbus_wdata_i = 16'h3333;
    gbus_we_i = 1'b1; gbus_acc_i = 1'b1; gbus_wdata_i = 16'h4444;
    tick();
    m[1][31:16] = 16'h3333;
    chk_state("R9 data bus beats global");
    dbus_we_i = 1'b1; dbus_acc_i = 1'b0; dbus_fld_i = 2'b11; dbus_wdata_i = 16'h8765;
    res_we_i = 1'b1; res_acc_i = 1'b0; res_data_i = 40'h12_3456_789A;
    scale_mode_i = 2'b00; sat_en_i = 1'b0;
    tick();
    m[0] = 40'h12_3456_789A;
    chk_state("R9 result beats data bus");
    dbus_we_i = 1'b1; dbus_acc_i = 1'b1; dbus_fld_i = 2'b00; dbus_wdata_i = 16'h5555;
    gbus_we_i = 1'b1; gbus_acc_i = 1'b1; gbus_wdata_i = 16'h6666;
    res_we_i = 1'b1; res_acc_i = 1'b0; res_data_i = 40'hFE_DCBA_9876;
    tick();
    m[0] = 40'hFE_DCBA_9876; m[1][15:0] = 16'h5555; m[1][31:16] = 16'h6666;
    chk_state("R9 different accumulators");

    // R6 R7 R8 scaling and saturation sweep
    for (int sh = 0; sh < 40; sh++) begin
      for (int k = 0; k < 4; k++) begin
        logic [39:0] base;
        base = 40'd1 << sh;
        case (k)
          0: base = base;
          1: base = -base;
          2: base = base - 40'd1;
          default: base = -base - 40'd1;
        endcase
        for (int md = 0; md < 4; md++) begin
          for (int st = 0; st < 2; st++) begin
            rwr(sh[0] ^ md[0], base, 2'(md), st[0], (sh % 5) == 0 && k == st);
            chk_state(st ? "R7 R8 saturating result" : "R6 scaled result");
          end
        end
      end
    end

    // R8 sticky, then clear
    rwr(1'b0, 40'h00_8000_0000, 2'b00, 1'b1, 1'b0);
    chk_state("R8 clamp sets flag");
    for (int i = 0; i < 4; i++) begin
      rwr(1'b1, 40'(i), 2'b00, 1'b1, 1'b0);
      chk_state("R8 flag holds");
    end
    rwr(1'b0, 40'hFF_0000_0000, 2'b00, 1'b1, 1'b1);
    chk_state("R8 clamp beats clear");
    lim_clr_i = 1'b1;
    tick();
    mlim = 1'b0;
    chk_state("R8 clear");

    // R1 asynchronous reset mid-cycle
    dwr(1'b1, 2'b01, 16'h7FFF);
    rwr(1'b0, 40'h7F_0000_0000, 2'b00, 1'b1, 1'b0);
    #0.5;
    rst_ni = 1'b0;
    #0.5;
    m[0] = '0; m[1] = '0; mlim = 1'b0;
    chk_state("R1 async reset");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule